// File: doc/BRIEF.md
# PUF Response Recovery Sequencer

This block runs the recovery side of an SRAM-based physical unclonable function. The response is corrected in four passes that share one soft-decision decoder. When started, the block reads the four raw power-up segments out of the SRAM. It keeps segment 0 in a working register and holds segments 1 to 3 in a private side buffer. The side buffer exists because the decoder later uses the same SRAM as scratch space, which destroys the raw contents.

For each pass the block addresses a ROM with the pass number. It takes two items from the ROM: the helper word and the per-bit error-probability indices. It forms the noisy codeword as the segment XOR the helper word. It hands that word and the probability indices to the external decoder, then waits. When the corrected codeword comes back, the block XORs it with the same helper word. It writes the result into the response slot chosen by the pass number. After the fourth slot is written, the block flags completion.

Top module: `puf_resp_seq`

## Requirements
- R1: While reset is held and after it is released, busy, done, decStart and sramRdEn are low and response is all zeros.
- R2: A start accepted in idle reads SRAM addresses 0, 1, 2, 3 on four consecutive cycles, one per cycle with one cycle of read latency. No other SRAM read happens during the run.
- R3: Pass k uses the original power-up segment k, even after the decoder has overwritten the SRAM, because segments 1 to 3 are kept in the side buffer.
- R4: In pass k, noisyWord equals segment k XOR the helper word read from ROM address k. It is presented together with a decStart pulse that lasts exactly one cycle, so a run contains exactly four decStart pulses.
- R5: While decStart is high, probIdx equals the probability data that the ROM returned for address k.
- R6: On the cycle after decDone in pass k, bits [k*SEG_W +: SEG_W] of response equal codeword XOR helper word k. All other slots are unchanged.
- R7: romAddr carries the pass index. It starts at 0 and advances by one only when decDone is high, so it holds its value while the decoder works.
- R8: done is high for exactly one cycle. That cycle is the one after the fourth slot write becomes visible. busy stays high from the cycle after an accepted start through the done cycle, then goes low.
- R9: A start pulse while busy is high is ignored: the run in progress is neither restarted nor disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a recovery run (accepted only in idle) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| sramRdEn | output | 1 | SRAM read enable |
| sramAddr | output | $clog2(NSEG) | SRAM segment address |
| sramRdData | input | SEG_W | SRAM read data, valid one cycle after the read |
| romAddr | output | $clog2(NSEG) | ROM address, equal to the pass index |
| romHelper | input | SEG_W | Helper word, valid one cycle after the address |
| romProb | input | SEG_W*PW | Probability indices, valid one cycle after the address |
| decStart | output | 1 | Decoder launch pulse |
| noisyWord | output | SEG_W | Noisy codeword for the decoder |
| probIdx | output | SEG_W*PW | Probability indices for the decoder |
| decDone | input | 1 | Decoder result valid |
| codeword | input | SEG_W | Corrected codeword |
| response | output | NSEG*SEG_W | Assembled stable response |

## Verification
The bench builds the block with SEG_W=16, PW=2 and NSEG=4. Sixteen-bit segments keep every slot readable in a 64-bit check value while leaving the four-pass sequence intact. The SRAM model inverts its contents at each decoder launch, so any reread of the SRAM after the first pass corrupts the result. Decoder latencies from 1 to 7 cycles exercise the hold of the pass index. A start pulse injected in the middle of a run checks that the run is neither restarted nor disturbed.

// File: rtl/puf_seq_pkg.sv
package puf_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_FETCH,
    ST_ISSUE,
    ST_WAIT,
    ST_WRAP,
    ST_FINI
  } seqState_t;

  typedef struct packed {
    logic issue;      // latch ROM data, form noisy word, launch decoder
    logic writeResp;  // store corrected slot
    logic advance;    // move next buffered segment into the working register
  } seqStrb_t;

endpackage

// File: rtl/puf_seq_ctrl.sv
module puf_seq_ctrl
  import puf_seq_pkg::*;
#(
  parameter int NSEG = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      start,
  input  logic                      decDone,
  output logic                      busy,
  output logic                      done,
  output logic                      sramRdEn,
  output logic [$clog2(NSEG)-1:0]   sramAddr,
  output logic [$clog2(NSEG)-1:0]   pass,
  output seqStrb_t                  strb
);

  localparam int PASS_W = $clog2(NSEG);
  localparam logic [PASS_W-1:0] LAST = PASS_W'(NSEG - 1);

  seqState_t st;
  logic [PASS_W-1:0] rdCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st    <= ST_IDLE;
      rdCnt <= '0;
      pass  <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          st    <= ST_READ;
          rdCnt <= '0;
          pass  <= '0;
        end
        ST_READ: begin
          rdCnt <= rdCnt + 1'b1;
          if (rdCnt == LAST) st <= ST_FETCH;
        end
        ST_FETCH: st <= ST_ISSUE;
        ST_ISSUE: st <= ST_WAIT;
        ST_WAIT: if (decDone) begin
          if (pass == LAST) st <= ST_WRAP;
          else begin
            pass <= pass + 1'b1;
            st   <= ST_FETCH;
          end
        end
        ST_WRAP: st <= ST_FINI;
        ST_FINI: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    sramRdEn       = (st == ST_READ);
    sramAddr       = rdCnt;
    strb.issue     = (st == ST_ISSUE);
    strb.writeResp = (st == ST_WAIT) && decDone;
    strb.advance   = (st == ST_WAIT) && decDone && (pass != LAST);
    busy           = (st != ST_IDLE);
    done           = (st == ST_FINI);
  end

  // R7
  pass_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st != ST_IDLE && !decDone) |=> $stable(pass));

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_WAIT && start && !decDone) |=> (st == ST_WAIT));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R2
  read_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (sramRdEn && sramAddr == '0));

endmodule

// File: rtl/puf_seq_dp.sv
module puf_seq_dp
  import puf_seq_pkg::*;
#(
  parameter int SEG_W = 256,
  parameter int NSEG  = 4,
  parameter int PW    = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  seqStrb_t                  strb,
  input  logic [$clog2(NSEG)-1:0]   pass,
  input  logic                      sramRdEn,
  input  logic [$clog2(NSEG)-1:0]   sramAddr,
  input  logic [SEG_W-1:0]          sramRdData,
  input  logic [SEG_W-1:0]          romHelper,
  input  logic [SEG_W*PW-1:0]       romProb,
  input  logic [SEG_W-1:0]          codeword,
  output logic                      decStart,
  output logic [SEG_W-1:0]          noisyWord,
  output logic [SEG_W*PW-1:0]       probIdx,
  output logic [NSEG*SEG_W-1:0]     response
);

  localparam int PASS_W = $clog2(NSEG);
  localparam int NBUF   = NSEG - 1;

  logic                capV;
  logic [PASS_W-1:0]   capIdx;
  logic [SEG_W-1:0]    curSeg;
  logic [SEG_W-1:0]    helperReg;
  logic [SEG_W-1:0]    sideBuf [NBUF];
  logic [SEG_W-1:0]    nextSeg;
  logic [NSEG-1:0]     slotWe;

  // Read-return pipeline aligned to the one-cycle SRAM latency.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capV   <= 1'b0;
      capIdx <= '0;
    end else begin
      capV   <= sramRdEn;
      capIdx <= sramAddr;
    end
  end

  // Side buffer keeps segments 1..NSEG-1 safe from decoder scratch writes.
  for (genvar i = 0; i < NBUF; i++) begin : g_buf
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) sideBuf[i] <= '0;
      else if (capV && capIdx == PASS_W'(i + 1)) sideBuf[i] <= sramRdData;
    end
  end

  always_comb begin
    nextSeg = '0;
    for (int i = 0; i < NBUF; i++)
      if (pass == PASS_W'(i)) nextSeg = sideBuf[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curSeg <= '0;
    else if (capV && capIdx == '0) curSeg <= sramRdData;
    else if (strb.advance) curSeg <= nextSeg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      decStart  <= 1'b0;
      noisyWord <= '0;
      probIdx   <= '0;
      helperReg <= '0;
    end else begin
      decStart <= strb.issue;
      if (strb.issue) begin
        noisyWord <= curSeg ^ romHelper;
        probIdx   <= romProb;
        helperReg <= romHelper;
      end
    end
  end

  for (genvar j = 0; j < NSEG; j++) begin : g_slot
    assign slotWe[j] = strb.writeResp && (pass == PASS_W'(j));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) response[j*SEG_W +: SEG_W] <= '0;
      else if (slotWe[j]) response[j*SEG_W +: SEG_W] <= codeword ^ helperReg;
    end

    // R6
    slot_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
      !slotWe[j] |=> $stable(response[j*SEG_W +: SEG_W]));
  end

  // R6
  one_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(slotWe));

  // R4
  launch_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    decStart |=> !decStart);

  // R5
  prob_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.issue |=> $stable(probIdx));

endmodule

// File: rtl/puf_resp_seq.sv
module puf_resp_seq
  import puf_seq_pkg::*;
#(
  parameter int SEG_W = 256,
  parameter int NSEG  = 4,
  parameter int PW    = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      start,
  output logic                      busy,
  output logic                      done,
  output logic                      sramRdEn,
  output logic [$clog2(NSEG)-1:0]   sramAddr,
  input  logic [SEG_W-1:0]          sramRdData,
  output logic [$clog2(NSEG)-1:0]   romAddr,
  input  logic [SEG_W-1:0]          romHelper,
  input  logic [SEG_W*PW-1:0]       romProb,
  output logic                      decStart,
  output logic [SEG_W-1:0]          noisyWord,
  output logic [SEG_W*PW-1:0]       probIdx,
  input  logic                      decDone,
  input  logic [SEG_W-1:0]          codeword,
  output logic [NSEG*SEG_W-1:0]     response
);

  localparam int PASS_W = $clog2(NSEG);

  seqStrb_t          strb;
  logic [PASS_W-1:0] pass;

  assign romAddr = pass;

  puf_seq_ctrl #(.NSEG(NSEG)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .decDone  (decDone),
    .busy     (busy),
    .done     (done),
    .sramRdEn (sramRdEn),
    .sramAddr (sramAddr),
    .pass     (pass),
    .strb     (strb)
  );

  puf_seq_dp #(.SEG_W(SEG_W), .NSEG(NSEG), .PW(PW)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .pass       (pass),
    .sramRdEn   (sramRdEn),
    .sramAddr   (sramAddr),
    .sramRdData (sramRdData),
    .romHelper  (romHelper),
    .romProb    (romProb),
    .codeword   (codeword),
    .decStart   (decStart),
    .noisyWord  (noisyWord),
    .probIdx    (probIdx),
    .response   (response)
  );

endmodule

// File: tb/sim_puf_resp_seq.sv
`timescale 1ns/1ps
module sim_puf_resp_seq;

  localparam int SW = 16;
  localparam int NS = 4;
  localparam int PW = 2;
  localparam int AW = 2;
  localparam int RW = NS * SW;

  typedef struct packed {
    logic [RW-1:0] raw;
    logic [RW-1:0] helper;
    logic [RW-1:0] flip;
    logic [3:0]    lat;
    logic          inject;
  } vec_t;

  localparam vec_t VEC [4] = '{
    '{raw: 64'h1234_5678_9ABC_DEF0, helper: 64'h0F0F_F0F0_3C3C_C3C3, flip: 64'h0001_0800_0000_4002, lat: 4'd1, inject: 1'b0},
    '{raw: 64'hFFFF_FFFF_FFFF_FFFF, helper: 64'hAAAA_5555_0000_FFFF, flip: 64'h0000_0000_0000_0000, lat: 4'd3, inject: 1'b0},
    '{raw: 64'h0000_0000_0000_0000, helper: 64'hDEAD_BEEF_CAFE_F00D, flip: 64'hFFFF_0000_8000_0001, lat: 4'd7, inject: 1'b0},
    '{raw: 64'h0123_4567_89AB_CDEF, helper: 64'h5A5A_A5A5_1111_EEEE, flip: 64'h0100_0010_0000_2000, lat: 4'd2, inject: 1'b1}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic busy, done, sramRdEn, decStart;
  logic [AW-1:0] sramAddr, romAddr;
  logic [SW-1:0] sramRdData = '0, romHelper = '0, noisyWord, codeword = '0;
  logic [SW*PW-1:0] romProb = '0, probIdx;
  logic decDone = 1'b0;
  logic [RW-1:0] response;

  always #2.5 clk = ~clk;

  puf_resp_seq #(.SEG_W(SW), .NSEG(NS), .PW(PW)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
    .sramRdEn(sramRdEn), .sramAddr(sramAddr), .sramRdData(sramRdData),
    .romAddr(romAddr), .romHelper(romHelper), .romProb(romProb),
    .decStart(decStart), .noisyWord(noisyWord), .probIdx(probIdx),
    .decDone(decDone), .codeword(codeword), .response(response)
  );

  int nChk = 0;
  int nErr = 0;

  // Models of the SRAM, ROM and decoder for the current vector.
  logic [RW-1:0] curRaw = '0, curHelper = '0, curFlip = '0;
  logic [3:0]    curLat = 4'd1;
  logic          scrambled = 1'b0;
  logic          decBusy = 1'b0;
  logic [3:0]    decCnt = '0;
  logic [SW-1:0] decIn = '0;
  int            decPass = 0;

  function automatic logic [SW*PW-1:0] probOf(input logic [AW-1:0] k);
    return {16{k}} ^ 32'hC3A5_5A3C;
  endfunction

  always @(posedge clk) begin
    if (start && !busy) begin
      scrambled <= 1'b0;
      decPass   <= 0;
    end
    if (sramRdEn)
      sramRdData <= scrambled ? ~curRaw[sramAddr*SW +: SW] : curRaw[sramAddr*SW +: SW];
    romHelper <= curHelper[romAddr*SW +: SW];
    romProb   <= probOf(romAddr);
    decDone   <= 1'b0;
    if (decStart) begin
      scrambled <= 1'b1;   // decoder uses the SRAM as scratch
      decBusy   <= 1'b1;
      decCnt    <= curLat;
      decIn     <= noisyWord;
    end else if (decBusy) begin
      if (decCnt == 4'd1) begin
        decBusy  <= 1'b0;
        decDone  <= 1'b1;
        codeword <= decIn ^ curFlip[decPass*SW +: SW];
        decPass  <= decPass + 1;
      end else decCnt <= decCnt - 1'b1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [RW-1:0] act, input logic [RW-1:0] exp);
    nChk++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runVec(input vec_t v);
    int rds = 0, lateRd = 0, launches = 0, cyc = 0, lastDoneCyc = -10;
    bit injected = 0, finished = 0, pendWrite = 0;
    int wk = 0;
    logic [RW-1:0] expResp = v.raw ^ v.flip;
    logic [RW-1:0] prevResp = response;
    curRaw = v.raw; curHelper = v.helper; curFlip = v.flip; curLat = v.lat;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy === 1'b1, "R8 busy after start", RW'(busy), 1);
    while (!finished && cyc < 400) begin
      if (injected && start) start = 1'b0;
      if (pendWrite) begin
        pendWrite = 0;
        for (int j = 0; j < NS; j++) begin
          logic [SW-1:0] e = (j <= wk) ? expResp[j*SW +: SW] : prevResp[j*SW +: SW];
          chk(response[j*SW +: SW] === e, "R6/R3 slot contents", RW'(response[j*SW +: SW]), RW'(e));
        end
      end
      if (sramRdEn) begin
        chk(sramAddr === AW'(rds), "R2 read address", RW'(sramAddr), RW'(rds));
        rds++;
        if (launches > 0) lateRd++;
      end
      if (decStart) begin
        chk(noisyWord === (v.raw[launches*SW +: SW] ^ v.helper[launches*SW +: SW]), "R4 noisy word",
            RW'(noisyWord), RW'(v.raw[launches*SW +: SW] ^ v.helper[launches*SW +: SW]));
        chk(probIdx === probOf(AW'(launches)), "R5 probability indices", RW'(probIdx), RW'(probOf(AW'(launches))));
        chk(romAddr === AW'(launches), "R7 rom address at launch", RW'(romAddr), RW'(launches));
        launches++;
      end
      if (decDone) begin
        chk(romAddr === AW'(launches - 1), "R7 rom address held", RW'(romAddr), RW'(launches - 1));
        pendWrite = 1; wk = launches - 1;
        if (launches == NS) lastDoneCyc = cyc;
      end
      if (done) begin
        chk(cyc == lastDoneCyc + 2, "R8 done timing", RW'(cyc), RW'(lastDoneCyc + 2));
        chk(busy === 1'b1, "R8 busy in done cycle", RW'(busy), 1);
        finished = 1;
      end
      if (v.inject && launches == 2 && !injected) begin
        start = 1'b1;   // R9: must be ignored
        injected = 1;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk(finished, "R8 run completes (watchdog)", RW'(finished), 1);
    chk(done === 1'b0 && busy === 1'b0, "R8 idle after done", RW'({busy, done}), 0);
    chk(rds == NS && lateRd == 0, "R2 read count", RW'(rds), RW'(NS));
    chk(launches == NS, v.inject ? "R9 start while busy ignored" : "R4 launch count", RW'(launches), RW'(NS));
    chk(response === expResp, "R6 final response", response, expResp);
  endtask

  initial begin
    #1_000_000;
    nChk++; nErr++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk({busy, done, decStart, sramRdEn} === 4'b0, "R1 outputs in reset", RW'({busy, done, decStart, sramRdEn}), 0);
    chk(response === '0, "R1 response in reset", response, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    // R1 after release, before any start
    chk({busy, done, decStart, sramRdEn} === 4'b0, "R1 outputs after reset", RW'({busy, done, decStart, sramRdEn}), 0);
    chk(response === '0, "R1 response after reset", response, 0);
    for (int i = 0; i < 4; i++) begin
      runVec(VEC[i]);
      repeat (2) @(negedge clk);
    end
    // Idle stays quiet without a start (R1/R2)
    repeat (3) @(negedge clk);
    chk({busy, sramRdEn, decStart} === 3'b0, "R2 no activity without start", RW'({busy, sramRdEn, decStart}), 0);
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end

endmodule